// File: doc/BRIEF.md
# Descriptor-Driven Audio Capture DMA

This block is a bus-master engine that moves a stream of 16-bit audio samples into system memory. Software builds a linked table of two-word descriptors in memory, writes the address of the first descriptor into the table-pointer register, and then sets the run and direction bits in the command register. The engine fetches each descriptor and fills the memory region it names with sample data, two samples per 32-bit word. It then moves on to the next descriptor.

Each descriptor can carry three flags. One raises an end-of-page status when its region is complete. One ends the walk after its region. One redirects the walk to a new descriptor address without moving any data. If an end-of-page arrives while software still has the previous one unacknowledged, the engine flags an error and stops issuing memory traffic until software reads the status register.

Top module: `capture_dma`

## Requirements
- R1: After reset the command, status and pointer registers read 0, no memory request is raised, and no sample is accepted.
- R2: Register port map, with each read returning data in the cycle after the read strobe. Address 0 is the command register: bit 0 is run and bit 3 is direction (1 = write to memory). Address 1 is status: bit 0 is end-of-page and bit 1 is error. Address 2 is the table pointer, whose bits 1:0 always read 0. All other bits read 0.
- R3: Writing the command register with bit 0 = 1 and bit 3 = 1 while stopped starts the walk. The engine reads descriptor word 0 (region base) at the pointer and word 1 at the pointer + 4. Word 1 holds bit 31 = end-of-table, bit 30 = end-of-page, bit 29 = jump and bits 15:0 = region byte count. If bit 3 is 0, no memory request is made.
- R4: The pointer register grows by 8 for every non-jump descriptor fetched, so a read returns the address of the next descriptor.
- R5: Each memory write carries two samples, with the earlier sample in bits 15:0. Writes start at the region base and step by 4. A region of N bytes (N a multiple of 4) gets exactly N/4 writes.
- R6: A descriptor with the jump bit moves no data. Its word 0 becomes the next descriptor address and is loaded into the pointer register.
- R7: Finishing a region whose descriptor has the end-of-page bit sets status bit 0. A status read returns the bit and clears it.
- R8: An end-of-page while status bit 0 is still set also sets status bit 1. Memory requests and sample intake then stop until a status read, which clears both bits and lets the walk continue.
- R9: After the region of an end-of-table descriptor, the engine makes no further fetch and accepts no samples until run is cleared. Setting run again restarts from the pointer register.
- R10: Clearing run while a data write is outstanding has no effect on that write. It completes, and then the engine stops without starting another write.
- R11: A memory request keeps its address, direction and write data unchanged until the cycle in which ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid the cycle after the strobe |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, taken when ready is high |
| mem_ready | input | 1 | Completes the current request |
| smp_valid | input | 1 | Sample valid |
| smp_data | input | 16 | Sample value |
| smp_ready | output | 1 | Sample accepted when high together with valid |

## Verification
The bench targets five cases.

- A second end-of-page with the first still pending: an engine that only set the flag would keep writing, and the bench would see writes and fetches during the pause window.
- A jump descriptor: a design that treated it as an ordinary region would write into its base or step the pointer by 8 instead of loading the target.
- End-of-table followed by a restart: an engine that kept fetching, or that restarted from a stale address, would show up in the fetch log.
- Run cleared while a write is outstanding under long memory latency: an engine that dropped the write would leave one write short, and one that ignored the stop would issue extra writes.
- Exact sample packing order: a design with the halves swapped would fail on the region contents.

// File: rtl/cdma_pkg.sv
package cdma_pkg;
  localparam logic [1:0] REG_CMD  = 2'd0;
  localparam logic [1:0] REG_STAT = 2'd1;
  localparam logic [1:0] REG_PTR  = 2'd2;

  localparam int CMD_RUN_BIT = 0;
  localparam int CMD_DIR_BIT = 3;

  localparam int DESC_EOT = 31;
  localparam int DESC_EOP = 30;
  localparam int DESC_JMP = 29;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH0, ST_FETCH1, ST_XFER,
    ST_RDONE, ST_CHECK, ST_PAUSE, ST_FIN
  } eng_state_t;
endpackage

// File: rtl/cdma_regs.sv
module cdma_regs
  import cdma_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [1:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          ptr_adv,
  input  logic          ptr_load,
  input  logic [DW-1:0] ptr_val,
  input  logic          eop_evt,
  output logic          run,
  output logic          start,
  output logic [DW-1:0] ptr,
  output logic          st_err
);
  localparam int PTR_STEP = 8;

  logic run_q, dir_q, eop_q, err_q;
  logic [DW-1:0] ptr_q, rdata_q;
  logic stat_rd, cmd_wr;
  logic unused_wbit;

  assign stat_rd = reg_rd && (reg_addr == REG_STAT);
  assign cmd_wr  = reg_wr && (reg_addr == REG_CMD);
  assign start   = cmd_wr && reg_wdata[CMD_RUN_BIT] && reg_wdata[CMD_DIR_BIT] && !run_q;
  assign unused_wbit = reg_wdata[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0; dir_q <= 1'b0; eop_q <= 1'b0; err_q <= 1'b0;
      ptr_q <= '0;   rdata_q <= '0;
    end else begin
      if (cmd_wr) begin
        run_q <= reg_wdata[CMD_RUN_BIT];
        dir_q <= reg_wdata[CMD_DIR_BIT];
      end
      if (ptr_load)
        ptr_q <= {ptr_val[DW-1:2], 2'b00};
      else if (ptr_adv)
        ptr_q <= ptr_q + DW'(PTR_STEP);
      else if (reg_wr && reg_addr == REG_PTR)
        ptr_q <= {reg_wdata[DW-1:2], 2'b00};
      // an event in the same cycle as a read survives; error only if the old flag stays pending
      eop_q <= eop_evt ? 1'b1 : (stat_rd ? 1'b0 : eop_q);
      err_q <= (eop_evt && eop_q && !stat_rd) ? 1'b1 : (stat_rd ? 1'b0 : err_q);
      if (reg_rd) begin
        unique case (reg_addr)
          REG_CMD:  rdata_q <= {{(DW-4){1'b0}}, dir_q, 2'b00, run_q};
          REG_STAT: rdata_q <= {{(DW-2){1'b0}}, err_q, eop_q};
          REG_PTR:  rdata_q <= ptr_q;
          default:  rdata_q <= '0;
        endcase
      end
    end
  end

  assign reg_rdata = rdata_q;
  assign run       = run_q;
  assign ptr       = ptr_q;
  assign st_err    = err_q;

  a_r8_err_needs_eop: assert property (@(posedge clk) disable iff (rst)
    err_q |-> eop_q);
  a_r7_read_clears: assert property (@(posedge clk) disable iff (rst)
    (stat_rd && !eop_evt) |=> (!eop_q && !err_q));
  a_r4_ptr_step: assert property (@(posedge clk) disable iff (rst)
    (ptr_adv && !ptr_load) |=> (ptr_q == $past(ptr_q) + DW'(PTR_STEP)));
endmodule

// File: rtl/cdma_packer.sv
module cdma_packer #(
  parameter int DW = 32,
  parameter int SW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          open,
  input  logic          smp_valid,
  input  logic [SW-1:0] smp_data,
  output logic          smp_ready,
  output logic          word_valid,
  output logic [DW-1:0] word,
  input  logic          take
);
  localparam int LANES = DW / SW;
  localparam int IW    = (LANES > 1) ? $clog2(LANES) : 1;

  logic [SW-1:0] lane_q [LANES];
  logic [IW-1:0] idx_q;
  logic          full_q;
  logic          accept;

  assign smp_ready = open && !full_q;
  assign accept    = smp_ready && smp_valid;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      idx_q  <= '0;
      full_q <= 1'b0;
    end else begin
      if (accept) begin
        lane_q[idx_q] <= smp_data;
        if (idx_q == IW'(LANES - 1)) begin
          idx_q  <= '0;
          full_q <= 1'b1;
        end else begin
          idx_q <= idx_q + 1'b1;
        end
      end
      if (take) full_q <= 1'b0;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign word[g*SW +: SW] = lane_q[g];
  end
  assign word_valid = full_q;

  a_r5_take_full: assert property (@(posedge clk) disable iff (rst)
    take |-> full_q);
  a_r5_full_holds: assert property (@(posedge clk) disable iff (rst)
    (full_q && !take && !clear) |=> full_q);
endmodule

// File: rtl/cdma_engine.sv
module cdma_engine
  import cdma_pkg::*;
#(
  parameter int DW    = 32,
  parameter int CNT_W = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          run,
  input  logic [DW-1:0] ptr,
  input  logic          st_err,
  output logic          ptr_adv,
  output logic          ptr_load,
  output logic [DW-1:0] ptr_val,
  output logic          eop_evt,
  output logic          mem_req,
  output logic          mem_we,
  output logic [DW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_ready,
  input  logic          pk_valid,
  input  logic [DW-1:0] pk_word,
  output logic          pk_take,
  output logic          pk_clear,
  output logic          pk_open
);
  localparam int WBYTES = DW / 8;

  eng_state_t    state;
  logic          req_q, we_q, eot_q, eop_q;
  logic [DW-1:0] addr_q, wdata_q, base_q;
  logic [CNT_W-1:0] cnt_q;
  logic          gap;
  logic          unused_rd;

  assign unused_rd = ^{mem_rdata[DESC_JMP-1:CNT_W]};
  assign gap       = (state == ST_XFER) && !req_q && run;

  assign ptr_adv  = (state == ST_FETCH1) && mem_ready && !mem_rdata[DESC_JMP];
  assign ptr_load = (state == ST_FETCH1) && mem_ready &&  mem_rdata[DESC_JMP];
  assign ptr_val  = base_q;
  assign eop_evt  = (state == ST_RDONE) && eop_q;
  assign pk_open  = gap;
  assign pk_take  = gap && pk_valid;
  assign pk_clear = (state == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE; req_q <= 1'b0; we_q <= 1'b0;
      addr_q <= '0; wdata_q <= '0; base_q <= '0; cnt_q <= '0;
      eot_q <= 1'b0; eop_q <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (start) begin
          req_q <= 1'b1; we_q <= 1'b0; addr_q <= ptr; state <= ST_FETCH0;
        end
        ST_FETCH0: if (mem_ready) begin
          base_q <= {mem_rdata[DW-1:2], 2'b00};
          addr_q <= addr_q + DW'(WBYTES);
          state  <= ST_FETCH1;
        end
        ST_FETCH1: if (mem_ready) begin
          addr_q <= base_q;
          if (mem_rdata[DESC_JMP]) begin
            state <= ST_FETCH0;
          end else begin
            req_q <= 1'b0;
            cnt_q <= mem_rdata[CNT_W-1:0];
            eot_q <= mem_rdata[DESC_EOT];
            eop_q <= mem_rdata[DESC_EOP];
            state <= (mem_rdata[CNT_W-1:0] == '0) ? ST_RDONE : ST_XFER;
          end
        end
        ST_XFER: begin
          if (req_q) begin
            if (mem_ready) begin
              req_q  <= 1'b0;
              we_q   <= 1'b0;
              addr_q <= addr_q + DW'(WBYTES);
              if (cnt_q <= CNT_W'(WBYTES)) begin
                cnt_q <= '0;
                state <= ST_RDONE;
              end else begin
                cnt_q <= cnt_q - CNT_W'(WBYTES);
              end
            end
          end else if (!run) begin
            state <= ST_IDLE;
          end else if (pk_valid) begin
            req_q <= 1'b1; we_q <= 1'b1; wdata_q <= pk_word;
          end
        end
        ST_RDONE: state <= ST_CHECK;
        ST_CHECK, ST_PAUSE: begin
          if (state == ST_PAUSE && !run) begin
            state <= ST_IDLE;
          end else if (st_err) begin
            state <= ST_PAUSE;
          end else if (eot_q) begin
            state <= ST_FIN;
          end else begin
            req_q <= 1'b1; we_q <= 1'b0; addr_q <= ptr; state <= ST_FETCH0;
          end
        end
        ST_FIN: if (!run) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign mem_req   = req_q;
  assign mem_we    = we_q;
  assign mem_addr  = addr_q;
  assign mem_wdata = wdata_q;

  a_r11_hold: assert property (@(posedge clk) disable iff (rst)
    (req_q && !mem_ready) |=> (req_q && $stable(addr_q) && $stable(we_q) && $stable(wdata_q)));
  a_r8_pause_quiet: assert property (@(posedge clk) disable iff (rst)
    (state == ST_PAUSE) |-> (!req_q && !pk_open));
  a_r9_fin_quiet: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FIN) |-> (!req_q && !pk_open));
  a_r5_aligned: assert property (@(posedge clk) disable iff (rst)
    req_q |-> (addr_q[1:0] == 2'b00));
  a_r6_jump_no_write: assert property (@(posedge clk) disable iff (rst)
    ptr_load |=> !we_q);
endmodule

// File: rtl/capture_dma.sv
module capture_dma #(
  parameter int DW    = 32,
  parameter int SW    = 16,
  parameter int CNT_W = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [1:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [DW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_ready,
  input  logic          smp_valid,
  input  logic [SW-1:0] smp_data,
  output logic          smp_ready
);
  logic          run, start, st_err, ptr_adv, ptr_load, eop_evt;
  logic [DW-1:0] ptr, ptr_val, pk_word;
  logic          pk_valid, pk_take, pk_clear, pk_open;

  cdma_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ptr_adv(ptr_adv),
    .ptr_load(ptr_load), .ptr_val(ptr_val), .eop_evt(eop_evt), .run(run),
    .start(start), .ptr(ptr), .st_err(st_err)
  );

  cdma_engine #(.DW(DW), .CNT_W(CNT_W)) u_engine (
    .clk(clk), .rst(rst), .start(start), .run(run), .ptr(ptr), .st_err(st_err),
    .ptr_adv(ptr_adv), .ptr_load(ptr_load), .ptr_val(ptr_val), .eop_evt(eop_evt),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ready(mem_ready), .pk_valid(pk_valid),
    .pk_word(pk_word), .pk_take(pk_take), .pk_clear(pk_clear), .pk_open(pk_open)
  );

  cdma_packer #(.DW(DW), .SW(SW)) u_packer (
    .clk(clk), .rst(rst), .clear(pk_clear), .open(pk_open), .smp_valid(smp_valid),
    .smp_data(smp_data), .smp_ready(smp_ready), .word_valid(pk_valid),
    .word(pk_word), .take(pk_take)
  );
endmodule

// File: tb/capture_dma_test.sv
module capture_dma_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic        reg_wr = 0, reg_rd = 0;
  logic [1:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic        mem_req, mem_we, mem_ready = 0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = 0;
  logic        smp_valid = 0, smp_ready;
  logic [15:0] smp_data = 0;

  capture_dma uut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ready(mem_ready), .smp_valid(smp_valid), .smp_data(smp_data),
    .smp_ready(smp_ready)
  );

  logic [31:0] mem [0:1023];
  logic [31:0] fetch_log [0:63];
  logic [31:0] last_wr_addr = 0;
  int lat_cfg = 1, lat_cnt = 0, wr_cnt = 0, fetch_cnt = 0;
  int req_cyc = 0, rdy_cyc = 0, seq = 0;
  int checks = 0, fails = 0;
  logic src_on = 0, fire = 0, done = 0;

  // memory model: ready is raised lat_cfg negedges after a request is seen
  always @(negedge clk) begin
    if (mem_ready) begin
      mem_ready = 0;
      lat_cnt = 0;
    end else if (mem_req) begin
      if (lat_cnt >= lat_cfg) begin
        mem_ready = 1;
        if (mem_we) begin
          mem[mem_addr[11:2]] = mem_wdata;
          last_wr_addr = mem_addr;
          wr_cnt++;
        end else begin
          mem_rdata = mem[mem_addr[11:2]];
          fetch_log[fetch_cnt % 64] = mem_addr;
          fetch_cnt++;
        end
      end else begin
        lat_cnt++;
      end
    end
  end

  always @(posedge clk) begin
    fire <= smp_valid && smp_ready;
    if (mem_req) req_cyc <= req_cyc + 1;
    if (smp_ready) rdy_cyc <= rdy_cyc + 1;
  end

  always @(negedge clk) begin
    if (fire) seq++;
    smp_valid = src_on;
    smp_data  = 16'(seq);
  end

  function automatic logic [31:0] pair(int s);
    return {16'(s + 1), 16'(s)};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic reg_write(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic reg_read(logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1; reg_addr = a;
    @(negedge clk);
    reg_rd = 0;
    d = reg_rdata;
  endtask

  task automatic wait_writes(int n);
    for (int i = 0; i < 3000 && wr_cnt < n; i++) @(negedge clk);
    repeat (10) @(negedge clk);
  endtask

  task automatic test_reset();
    logic [31:0] d;
    chk("R1 mem_req", 32'(mem_req), 0);
    chk("R1 smp_ready", 32'(smp_ready), 0);
    reg_read(2'd0, d); chk("R1 command", d, 0);
    reg_read(2'd1, d); chk("R1 status", d, 0);
    reg_read(2'd2, d); chk("R1 pointer", d, 0);
  endtask

  task automatic test_regmap();
    logic [31:0] d;
    int r0;
    reg_write(2'd2, 32'h0000_01F3);
    reg_read(2'd2, d); chk("R2 pointer low bits", d, 32'h0000_01F0);
    reg_write(2'd0, 32'hFFFF_FFFE);
    reg_read(2'd0, d); chk("R2 command bits", d, 32'h0000_0008);
    r0 = req_cyc;
    reg_write(2'd0, 32'h0000_0001);
    repeat (20) @(negedge clk);
    chk("R3 no start without direction", 32'(req_cyc - r0), 0);
    reg_read(2'd0, d); chk("R2 run readback", d, 32'h0000_0001);
    reg_write(2'd0, 32'h0);
  endtask

  task automatic test_main();
    logic [31:0] d;
    int s0, f0, w0;
    mem[32'h100 >> 2] = 32'h0000_0400; mem[32'h104 >> 2] = 32'h4000_0008;
    mem[32'h108 >> 2] = 32'h0000_0500; mem[32'h10C >> 2] = 32'h8000_0010;
    s0 = seq; f0 = fetch_cnt; w0 = wr_cnt;
    reg_write(2'd2, 32'h100);
    src_on = 1;
    reg_write(2'd0, 32'h9);
    wait_writes(w0 + 6);
    chk("R3 fetch word0", fetch_log[f0 % 64], 32'h100);
    chk("R3 fetch word1", fetch_log[(f0 + 1) % 64], 32'h104);
    chk("R3 second descriptor", fetch_log[(f0 + 2) % 64], 32'h108);
    chk("R5 region0 word0", mem[32'h400 >> 2], pair(s0));
    chk("R5 region0 word1", mem[32'h404 >> 2], pair(s0 + 2));
    chk("R5 region1 word0", mem[32'h500 >> 2], pair(s0 + 4));
    chk("R5 region1 word3", mem[32'h50C >> 2], pair(s0 + 10));
    chk("R5 write count", 32'(wr_cnt - w0), 6);
    reg_read(2'd2, d); chk("R4 pointer after two", d, 32'h110);
    reg_read(2'd1, d); chk("R7 status eop", d, 32'h1);
    reg_read(2'd1, d); chk("R7 status cleared", d, 32'h0);
    repeat (30) @(negedge clk);
    chk("R9 no fetch after end", 32'(fetch_cnt - f0), 4);
    chk("R9 no sample intake", 32'(smp_ready), 0);
    // restart after clearing run
    mem[32'h200 >> 2] = 32'h0000_0680; mem[32'h204 >> 2] = 32'h8000_0004;
    reg_write(2'd0, 32'h8);
    reg_write(2'd2, 32'h200);
    s0 = seq; f0 = fetch_cnt; w0 = wr_cnt;
    reg_write(2'd0, 32'h9);
    wait_writes(w0 + 1);
    chk("R9 restart fetch", fetch_log[f0 % 64], 32'h200);
    chk("R9 restart data", mem[32'h680 >> 2], pair(s0));
    reg_write(2'd0, 32'h8);
  endtask

  task automatic test_jump();
    logic [31:0] d;
    int s0, f0, w0;
    mem[32'h300 >> 2] = 32'h0000_0340; mem[32'h304 >> 2] = 32'h2000_000C;
    mem[32'h340 >> 2] = 32'h0000_0600; mem[32'h344 >> 2] = 32'h8000_0008;
    s0 = seq; f0 = fetch_cnt; w0 = wr_cnt;
    reg_write(2'd2, 32'h300);
    reg_write(2'd0, 32'h9);
    wait_writes(w0 + 2);
    repeat (20) @(negedge clk);
    chk("R6 jump target fetch", fetch_log[(f0 + 2) % 64], 32'h340);
    chk("R6 total fetches", 32'(fetch_cnt - f0), 4);
    chk("R6 only target region written", 32'(wr_cnt - w0), 2);
    chk("R6 target data", mem[32'h604 >> 2], pair(s0 + 2));
    reg_read(2'd2, d); chk("R6 pointer after jump", d, 32'h348);
    reg_write(2'd0, 32'h8);
  endtask

  task automatic test_error();
    logic [31:0] d;
    int s0, f0, w0, r0, y0;
    mem[32'h700 >> 2] = 32'h0000_0800; mem[32'h704 >> 2] = 32'h4000_0004;
    mem[32'h708 >> 2] = 32'h0000_0810; mem[32'h70C >> 2] = 32'h4000_0004;
    mem[32'h710 >> 2] = 32'h0000_0820; mem[32'h714 >> 2] = 32'h8000_0004;
    s0 = seq; f0 = fetch_cnt; w0 = wr_cnt;
    reg_write(2'd2, 32'h700);
    reg_write(2'd0, 32'h9);
    wait_writes(w0 + 2);
    r0 = req_cyc; y0 = rdy_cyc;
    repeat (30) @(negedge clk);
    chk("R8 no requests while paused", 32'(req_cyc - r0), 0);
    chk("R8 no samples while paused", 32'(rdy_cyc - y0), 0);
    chk("R8 fetches held", 32'(fetch_cnt - f0), 4);
    reg_read(2'd1, d); chk("R8 error and eop", d, 32'h3);
    wait_writes(w0 + 3);
    chk("R8 resumed data", mem[32'h820 >> 2], pair(s0 + 4));
    reg_read(2'd1, d); chk("R8 both cleared", d, 32'h0);
    reg_read(2'd2, d); chk("R4 pointer after three", d, 32'h718);
    reg_write(2'd0, 32'h8);
  endtask

  task automatic test_stop();
    logic [31:0] d, a;
    int w, w0, r0, y0;
    logic seen;
    mem[32'h900 >> 2] = 32'h0000_0A00; mem[32'h904 >> 2] = 32'h8000_0040;
    lat_cfg = 6;
    w0 = wr_cnt;
    reg_write(2'd2, 32'h900);
    reg_write(2'd0, 32'h9);
    seen = 0; w = 0; a = 0;
    for (int i = 0; i < 3000 && !seen; i++) begin
      @(negedge clk); #1;
      if (wr_cnt >= w0 + 2 && mem_req && mem_we && !mem_ready) begin
        seen = 1; w = wr_cnt; a = mem_addr;
      end
    end
    reg_write(2'd0, 32'h8);
    repeat (20) @(negedge clk);
    r0 = req_cyc; y0 = rdy_cyc;
    repeat (30) @(negedge clk);
    chk("R10 in-flight write completed only", 32'(wr_cnt), 32'(w + 1));
    chk("R11 completed address held", last_wr_addr, a);
    chk("R10 no requests after stop", 32'(req_cyc - r0), 0);
    chk("R10 no samples after stop", 32'(rdy_cyc - y0), 0);
    reg_read(2'd2, d); chk("R4 pointer one descriptor", d, 32'h908);
    lat_cfg = 1;
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 32'h0;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    test_reset();
    test_regmap();
    test_main();
    test_jump();
    test_error();
    test_stop();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule